// File: doc/BRIEF.md
# EEPROM Configuration Loader with Checksum

This block runs the startup fetch of the device setup from an external serial EEPROM. It issues single-byte read requests to an I2C master, which sits outside the block. Each returned byte is steered to a configuration register write port or to a compensation table write port. While the bytes arrive, the block keeps an 8-bit additive checksum over them.

The fetch reads three regions in order:
- fourteen configuration bytes at addresses 1 to 14;
- the stored checksum at address 15;
- six-byte table blocks, starting at address 16.

The first byte of each table block is a breakpoint. The fetch ends after the first block, other than block 0, whose breakpoint is 255. This means at least two blocks and at most sixteen blocks are read. When the fetch ends, the block raises `done`. It then either enables normal operation or latches a sticky EEPROM error, which also drives an active-low error line.

Top module: `cfg_loader`

## Requirements
- R1: In the cycle after reset is released, `rd_req` is high with `rd_addr` = 1 and `busy` is high. `busy` stays high until `done` rises. `busy`, `done`, `cfg_valid`, `ee_err` and `rd_req` are 0 and `err_n` is 1 during reset.
- R2: Addresses are requested one at a time in ascending order with no gaps, starting at 1. A request holds `rd_addr` stable until `rd_ack`.
- R3: A byte read from address 1 to 14 produces one `cfg_we` pulse with `cfg_addr` equal to the EEPROM address and `cfg_data` equal to the byte.
- R4: A byte read from address 16 or above produces one `tbl_we` pulse. `tbl_addr` counts 0, 1, 2 and so on, equal to the EEPROM address minus 16. Address 15 writes to neither port.
- R5: Table block k occupies addresses 16+6k to 21+6k, and its breakpoint is the byte at 16+6k. The fetch stops after the last byte of the first block with k ≥ 1 whose breakpoint is 255. A breakpoint of 255 in block 0 does not end the fetch.
- R6: If block 15 completes without a terminating breakpoint, the fetch stops after address 111 with `ee_err` set and `cfg_valid` low.
- R7: The checksum is the 8-bit sum of bytes 1 to 14 plus every table byte through the final block. If it equals the byte at address 15, `done` rises with `cfg_valid` = 1 and `ee_err` = 0.
- R8: On a checksum mismatch, `done` rises with `ee_err` = 1, `err_n` = 0 and `cfg_valid` = 0.
- R9: A read returned with `rd_err` high ends the fetch at once. That byte is not written, no further reads are issued, and `ee_err` is set.
- R10: `ee_err` stays set until the next reset. A reset during a fetch restarts the fetch from address 1 with the error cleared.
- R11: An EEPROM that reads as all zeros is never accepted. It ends through the missing-terminator path after sixteen blocks, not through a checksum decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; its release starts a fetch |
| rd_req | output | 1 | Byte read request to the bus master |
| rd_addr | output | 8 | EEPROM byte address of the request |
| rd_ack | input | 1 | One-cycle pulse: read finished |
| rd_data | input | 8 | Byte returned with `rd_ack` |
| rd_err | input | 1 | Bus failure flag, valid with `rd_ack` |
| cfg_we | output | 1 | Configuration register write strobe |
| cfg_addr | output | 4 | Configuration register index |
| cfg_data | output | 8 | Configuration register data |
| tbl_we | output | 1 | Table RAM write strobe |
| tbl_addr | output | 7 | Table RAM byte index |
| tbl_data | output | 8 | Table RAM data |
| busy | output | 1 | Fetch in progress |
| done | output | 1 | Fetch finished; stays high until reset |
| cfg_valid | output | 1 | Setup accepted, normal operation allowed |
| ee_err | output | 1 | Sticky EEPROM error |
| err_n | output | 1 | Active-low error line |

## Verification
The bench builds the loader with its default parameters: fourteen configuration bytes, six-byte blocks, and a table of two to sixteen blocks. With these values, both ends of the table length can be reached in a single fetch of at most 111 bytes. One fetch runs the shortest table while also placing a 255 in block 0. Other fetches cover the full sixteen-block table with and without a terminator, the all-zero image, and a bus error inside the table. Responder latencies of zero to two cycles exercise the request hold and back-to-back address stepping.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [1:0] {
    LD_LAUNCH,
    LD_WAIT,
    LD_CHECK,
    LD_DONE
  } ld_state_e;
endpackage

// File: rtl/cfg_loader_seq.sv
module cfg_loader_seq
  import cfg_loader_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CFG_BYTES = 14,
  parameter int BLK_BYTES = 6,
  parameter int MIN_BLK   = 2,
  parameter int MAX_BLK   = 16,
  parameter int END_MARK  = 255
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  input  logic              csum_ok,
  output logic              byte_v,
  output logic              busy,
  output logic              done,
  output logic              cfg_valid,
  output logic              ee_err,
  output logic              err_n
);
  localparam int TBL_BASE = CFG_BYTES + 2;
  localparam int OFF_W    = $clog2(BLK_BYTES);
  localparam int BLK_W    = $clog2(MAX_BLK) + 1;
  localparam int MAX_ADDR = TBL_BASE + BLK_BYTES * MAX_BLK - 1;

  ld_state_e        state;
  logic [OFF_W-1:0] off;
  logic [BLK_W-1:0] blk;
  logic             bp_hit;
  logic             in_tbl;

  assign in_tbl = rd_addr >= ADDR_W'(TBL_BASE);
  assign byte_v = (state == LD_WAIT) && rd_ack && !rd_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= LD_LAUNCH;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      off       <= '0;
      blk       <= '0;
      bp_hit    <= 1'b0;
      busy      <= 1'b0;
      done      <= 1'b0;
      cfg_valid <= 1'b0;
      ee_err    <= 1'b0;
      err_n     <= 1'b1;
    end else begin
      case (state)
        LD_LAUNCH: begin
          rd_req  <= 1'b1;
          rd_addr <= ADDR_W'(1);
          busy    <= 1'b1;
          state   <= LD_WAIT;
        end
        LD_WAIT: begin
          if (rd_ack) begin
            if (rd_err) begin
              rd_req <= 1'b0;
              busy   <= 1'b0;
              done   <= 1'b1;
              ee_err <= 1'b1;
              err_n  <= 1'b0;
              state  <= LD_DONE;
            end else if (in_tbl) begin
              if (off == '0)
                bp_hit <= (rd_data == DATA_W'(END_MARK)) && (blk >= BLK_W'(MIN_BLK - 1));
              if (off == OFF_W'(BLK_BYTES - 1)) begin
                off <= '0;
                blk <= blk + 1'b1;
                if (bp_hit) begin
                  rd_req <= 1'b0;
                  state  <= LD_CHECK;
                end else if (blk == BLK_W'(MAX_BLK - 1)) begin
                  rd_req <= 1'b0;
                  busy   <= 1'b0;
                  done   <= 1'b1;
                  ee_err <= 1'b1;
                  err_n  <= 1'b0;
                  state  <= LD_DONE;
                end else begin
                  rd_addr <= rd_addr + 1'b1;
                end
              end else begin
                off     <= off + 1'b1;
                rd_addr <= rd_addr + 1'b1;
              end
            end else begin
              rd_addr <= rd_addr + 1'b1;
            end
          end
        end
        LD_CHECK: begin
          busy  <= 1'b0;
          done  <= 1'b1;
          state <= LD_DONE;
          if (csum_ok) begin
            cfg_valid <= 1'b1;
          end else begin
            ee_err <= 1'b1;
            err_n  <= 1'b0;
          end
        end
        default: state <= LD_DONE;
      endcase
    end
  end

  // R2: an open request keeps its address until answered
  p_req_hold_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr));
  // R2: after a good byte the next request is the following address
  p_addr_step_r2: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack && !rd_err |=> !rd_req || (rd_addr == $past(rd_addr) + 1'b1));
  // R6: never request beyond the last byte of the largest table
  p_addr_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr >= ADDR_W'(1)) && (rd_addr <= ADDR_W'(MAX_ADDR)));
  // R9: a failed read stops the fetch with the error latched
  p_bus_err_stop_r9: assert property (@(posedge clk) disable iff (rst)
    rd_req && rd_ack && rd_err |=> !rd_req && ee_err);
  // R10: the error flag never clears outside reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    ee_err |=> ee_err);
  // R7: acceptance only at the end of a clean fetch
  p_valid_done_r7: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> done && !busy && !ee_err);
endmodule

// File: rtl/cfg_loader_sum.sv
module cfg_loader_sum #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CFG_BYTES = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_v,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              csum_ok
);
  localparam int CSUM_ADDR = CFG_BYTES + 1;

  logic [DATA_W-1:0] acc;
  logic [DATA_W-1:0] stored;
  logic              is_csum;

  assign is_csum = addr == ADDR_W'(CSUM_ADDR);
  assign csum_ok = acc == stored;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      stored <= '0;
    end else if (byte_v) begin
      if (is_csum) stored <= data;
      else         acc    <= acc + data;
    end
  end

  // R7: the running sum moves only when a byte is accepted
  p_acc_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !byte_v |=> $stable(acc) && $stable(stored));
endmodule

// File: rtl/cfg_loader_route.sv
module cfg_loader_route #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CFG_BYTES = 14,
  parameter int CFG_AW    = 4,
  parameter int TBL_AW    = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              byte_v,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [DATA_W-1:0] tbl_data
);
  localparam int TBL_BASE = CFG_BYTES + 2;

  logic [TBL_AW-1:0] tbl_next;
  logic              to_cfg;
  logic              to_tbl;

  assign to_cfg = byte_v && (addr >= ADDR_W'(1)) && (addr <= ADDR_W'(CFG_BYTES));
  assign to_tbl = byte_v && (addr >= ADDR_W'(TBL_BASE));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_we   <= 1'b0;
      cfg_addr <= '0;
      cfg_data <= '0;
      tbl_we   <= 1'b0;
      tbl_addr <= '0;
      tbl_data <= '0;
      tbl_next <= '0;
    end else begin
      cfg_we <= to_cfg;
      tbl_we <= to_tbl;
      if (to_cfg) begin
        cfg_addr <= addr[CFG_AW-1:0];
        cfg_data <= data;
      end
      if (to_tbl) begin
        tbl_addr <= tbl_next;
        tbl_data <= data;
        tbl_next <= tbl_next + 1'b1;
      end
    end
  end

  // R3: configuration writes land only in the register window
  p_cfg_range_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_we |-> (cfg_addr >= CFG_AW'(1)) && (cfg_addr <= CFG_AW'(CFG_BYTES)));
  // R4: one byte goes to one destination
  p_one_port_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, tbl_we}));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CFG_BYTES = 14,
  parameter int BLK_BYTES = 6,
  parameter int MIN_BLK   = 2,
  parameter int MAX_BLK   = 16,
  parameter int END_MARK  = 255,
  localparam int CFG_AW   = $clog2(CFG_BYTES + 1),
  localparam int TBL_AW   = $clog2(BLK_BYTES * MAX_BLK)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_err,
  output logic              cfg_we,
  output logic [CFG_AW-1:0] cfg_addr,
  output logic [DATA_W-1:0] cfg_data,
  output logic              tbl_we,
  output logic [TBL_AW-1:0] tbl_addr,
  output logic [DATA_W-1:0] tbl_data,
  output logic              busy,
  output logic              done,
  output logic              cfg_valid,
  output logic              ee_err,
  output logic              err_n
);
  logic byte_v;
  logic csum_ok;

  cfg_loader_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BYTES(CFG_BYTES),
    .BLK_BYTES(BLK_BYTES), .MIN_BLK(MIN_BLK), .MAX_BLK(MAX_BLK),
    .END_MARK(END_MARK)
  ) seq_i (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
    .rd_data(rd_data), .rd_err(rd_err),
    .csum_ok(csum_ok), .byte_v(byte_v),
    .busy(busy), .done(done), .cfg_valid(cfg_valid),
    .ee_err(ee_err), .err_n(err_n)
  );

  cfg_loader_sum #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BYTES(CFG_BYTES)
  ) sum_i (
    .clk(clk), .rst(rst), .byte_v(byte_v),
    .addr(rd_addr), .data(rd_data), .csum_ok(csum_ok)
  );

  cfg_loader_route #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_BYTES(CFG_BYTES),
    .CFG_AW(CFG_AW), .TBL_AW(TBL_AW)
  ) route_i (
    .clk(clk), .rst(rst), .byte_v(byte_v),
    .addr(rd_addr), .data(rd_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data)
  );

  // R8: the error line mirrors the error flag
  p_pin_r8: assert property (@(posedge clk) disable iff (rst)
    err_n == !ee_err);
  // R1: busy and done never overlap
  p_busy_done_r1: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));
endmodule

// File: tb/cfg_loader_tb_top.sv
module cfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rd_ack = 1'b0;
  logic [7:0] rd_data = 8'h00;
  logic       rd_err = 1'b0;
  logic       rd_req, cfg_we, tbl_we, busy, done, cfg_valid, ee_err, err_n;
  logic [7:0] rd_addr, cfg_data, tbl_data;
  logic [3:0] cfg_addr;
  logic [6:0] tbl_addr;

  always #4 clk = ~clk;

  cfg_loader dut_i (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .busy(busy), .done(done), .cfg_valid(cfg_valid),
    .ee_err(ee_err), .err_n(err_n)
  );

  logic [7:0] img [256];
  int lat = 0;
  int err_at = 0;
  int wcnt = 0;
  int rd_seq = 1;
  int got_cfg = 0;
  int got_tbl = 0;
  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // byte responder
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ack) begin
        rd_ack = 1'b0;
        rd_err = 1'b0;
        wcnt = 0;
      end else if (rd_req && !rst) begin
        if (wcnt >= lat) begin
          chk(int'(rd_addr) == rd_seq, "R2 read order", int'(rd_addr), rd_seq);
          rd_seq++;
          rd_data = img[rd_addr];
          rd_err  = (int'(rd_addr) == err_at);
          rd_ack  = 1'b1;
        end else begin
          wcnt++;
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cfg_we) begin
        chk(int'(cfg_addr) == got_cfg + 1, "R3 cfg index", int'(cfg_addr), got_cfg + 1);
        chk(cfg_data == img[cfg_addr], "R3 cfg data", int'(cfg_data), int'(img[cfg_addr]));
        got_cfg++;
      end
      if (tbl_we) begin
        chk(int'(tbl_addr) == got_tbl, "R4 table index", int'(tbl_addr), got_tbl);
        chk(tbl_data == img[16 + int'(tbl_addr)], "R4 table data", int'(tbl_data),
            int'(img[16 + int'(tbl_addr)]));
        got_tbl++;
      end
      if (err_n == ee_err) chk(1'b0, "R8 error line", int'(err_n), int'(!ee_err));
    end
  end

  task automatic build(input int seed, input int term, input bit bp0_mark);
    int s;
    for (int a = 0; a < 256; a++) img[a] = 8'((a * 37 + seed * 11) & 255);
    for (int k = 0; k < 16; k++) img[16 + 6 * k] = 8'(k * 3 + 1);
    if (bp0_mark) img[16] = 8'd255;
    if (term >= 0) img[16 + 6 * term] = 8'd255;
    s = 0;
    for (int a = 1; a <= 14; a++) s += int'(img[a]);
    for (int a = 16; a < 16 + 6 * ((term >= 0) ? term + 1 : 16); a++) s += int'(img[a]);
    img[15] = 8'(s & 255);
  endtask

  task automatic kick();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rd_seq = 1;
    got_cfg = 0;
    got_tbl = 0;
    chk(!busy && !done && !cfg_valid && !ee_err && !rd_req, "R1 reset state",
        int'({busy, done, cfg_valid, ee_err, rd_req}), 0);
    chk(err_n == 1'b1, "R10 error cleared by reset", int'(err_n), 1);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_req && rd_addr == 8'd1 && busy, "R1 first request", int'(rd_addr), 1);
  endtask

  task automatic run(input string tag);
    int nblk, last, s, sr, reads, ecfg, etbl, t;
    bit term, fail;
    nblk = 16; term = 0;
    for (int k = 1; k < 16; k++)
      if (!term && img[16 + 6 * k] == 8'd255) begin nblk = k + 1; term = 1; end
    last = 16 + 6 * nblk - 1;
    s = 0;
    for (int a = 1; a <= 14; a++) s += int'(img[a]);
    for (int a = 16; a <= last; a++) s += int'(img[a]);
    if (err_at >= 1 && err_at <= last) begin
      reads = err_at; sr = err_at - 1; fail = 1;
    end else begin
      reads = last; sr = last; fail = !term || ((s & 255) != int'(img[15]));
    end
    ecfg = (sr >= 14) ? 14 : sr;
    etbl = (sr >= 16) ? sr - 15 : 0;
    kick();
    t = 0;
    while (!done && t < 2000) begin
      chk(busy, "R1 busy during fetch", int'(busy), 1);
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    chk(done && !busy, {tag, " done"}, int'({done, busy}), 2);
    chk(rd_seq - 1 == reads, {tag, " read count"}, rd_seq - 1, reads);
    chk(got_cfg == ecfg, {tag, " R3 cfg count"}, got_cfg, ecfg);
    chk(got_tbl == etbl, {tag, " R4 table count"}, got_tbl, etbl);
    chk(ee_err == fail, {tag, " error flag"}, int'(ee_err), int'(fail));
    chk(cfg_valid == !fail, {tag, " valid flag"}, int'(cfg_valid), int'(!fail));
    repeat (4) @(negedge clk);
    chk(ee_err == fail && !rd_req, "R10 flag held, no more reads",
        int'({ee_err, rd_req}), int'({fail, 1'b0}));
  endtask

  initial begin
    for (int a = 0; a < 256; a++) img[a] = 8'h00;
    // R5 / R7: three blocks, good sum
    build(1, 2, 1'b0); lat = 1; err_at = 0; run("R7 three blocks");
    // R5: 255 in block 0 does not terminate; shortest table
    build(2, 1, 1'b1); lat = 0; run("R5 minimum table");
    // R8: corrupted stored sum
    build(3, 3, 1'b0); img[15] = img[15] + 8'd1; lat = 2; run("R8 bad checksum");
    // R11 / R6: all-zero image
    for (int a = 0; a < 256; a++) img[a] = 8'h00;
    lat = 0; run("R11 all zeros");
    // R6: sixteen blocks, terminator at the last one
    build(4, 15, 1'b0); lat = 1; run("R6 full table accepted");
    // R6: sixteen blocks, no terminator
    build(5, -1, 1'b0); lat = 1; run("R6 no terminator");
    // R9: bus failure inside the table
    build(6, 4, 1'b0); err_at = 20; lat = 1; run("R9 bus error");
    err_at = 0;
    // R10: reset during a fetch restarts it
    build(7, 2, 1'b0); lat = 2;
    kick();
    repeat (25) @(negedge clk);
    run("R10 restart");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule